// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap

This block produces the word address for a four-beat burst access to a synchronous memory. A burst opens when one of two address-strobe inputs is sampled low with the chip selected. The block then captures the full external address. Two strobes exist: a processor-side strobe that wins whenever it is live, and a controller-side strobe that can open a burst only while the processor strobe is high.

After a burst opens, the two low address bits follow a four-entry sequence. The sequence moves one step on each clock edge that samples the active-low advance input low. When advance is high, the address holds, which inserts a wait state. A static order input selects the sequence:
- linear ordering: start plus step count, modulo 4;
- interleaved ordering: start XOR step count.

The upper address bits stay as captured for the whole burst. A last-beat flag marks the fourth address of each pass. After that address the sequence wraps back to the start value.

A strobe that arrives while the chip is not selected closes the burst and leaves the sequencer idle. While the sequencer is idle, advance has no effect.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_o is all zeros and last_o is 0.
- R2: The chip counts as selected when ce_pri_ni=0, ce_hi_i=1 and ce_lo_ni=0. On an edge where strb_cpu_ni=0 and the chip is selected, addr_i is loaded and the step count returns to 0. The values of strb_ctl_ni and adv_ni on that edge do not matter. The next addr_o equals addr_i and last_o is 0.
- R3: On an edge where strb_ctl_ni=0, strb_cpu_ni=1 and the chip is selected, addr_i is loaded and the step count returns to 0.
- R4: While ce_pri_ni=1, strb_cpu_ni=0 is ignored. If strb_ctl_ni=1 on that edge, the burst in progress steps or holds according to adv_ni as if no strobe were present.
- R5: A strobe event on an edge where the chip is not selected makes the sequencer idle. A strobe event is strb_ctl_ni=0, or strb_cpu_ni=0 together with ce_pri_ni=0. When idle, the step count is 0, addr_o keeps the last captured address, last_o is 0, and adv_ni=0 has no effect until the next load. The sequencer is also idle after reset.
- R6: During a burst, on an edge with no strobe event, adv_ni=0 advances the step count by one and adv_ni=1 leaves addr_o and last_o unchanged.
- R7: With order_sel_i=0, addr_o[1:0] = (start + step) mod 4. A start of 01 gives 01, 10, 11, 00.
- R8: With order_sel_i=1, addr_o[1:0] = start XOR step. A start of 10 gives 10, 11, 00, 01.
- R9: last_o is 1 exactly while the step count is 3 in a burst. The next advance returns addr_o[1:0] to the start value and clears last_o.
- R10: addr_o above bit 1 changes only on a load. No carry from the low bits reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_pri_ni | input | 1 | Primary chip select, active low; also gates strb_cpu_ni |
| ce_hi_i | input | 1 | Secondary chip select, active high |
| ce_lo_ni | input | 1 | Secondary chip select, active low |
| strb_cpu_ni | input | 1 | Processor address strobe, active low, higher priority |
| strb_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | 0 linear, 1 interleaved ordering |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth address of a pass |

## Verification
All state changes on the rising edge that samples the controls. addr_o and last_o are driven directly from that state, so each result is visible one edge after its stimulus. The only exception is order_sel_i, which reaches addr_o combinationally and is held steady within each cycle.

The driver applies each cycle's inputs on the falling edge and pushes the expected address and flag into a queue at the same moment. The monitor pops and compares one time unit after the following rising edge. This gives exactly one edge of latency per entry.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_DESEL = 2'd2
  } strb_ev_e;
endpackage

// File: rtl/burst_start_qual.sv
module burst_start_qual
  import burst_seq_pkg::*;
(
  input  logic     ce_pri_ni,
  input  logic     ce_hi_i,
  input  logic     ce_lo_ni,
  input  logic     strb_cpu_ni,
  input  logic     strb_ctl_ni,
  output strb_ev_e ev_o
);
  logic sel, cpu_live, ctl_live;

  assign sel      = ~ce_pri_ni & ce_hi_i & ~ce_lo_ni;
  // processor strobe is blocked while the primary select is off
  assign cpu_live = ~strb_cpu_ni & ~ce_pri_ni;
  assign ctl_live = ~strb_ctl_ni;

  always_comb begin
    ev_o = EV_NONE;
    if (cpu_live || ctl_live) ev_o = sel ? EV_START : EV_DESEL;
  end
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strb_ev_e          ev_i,
  input  logic              adv_ni,
  output logic [BEAT_W-1:0] step_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] step_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      busy_q <= 1'b0;
    end else begin
      unique case (ev_i)
        EV_START: begin
          step_q <= '0;
          busy_q <= 1'b1;
        end
        EV_DESEL: begin
          step_q <= '0;
          busy_q <= 1'b0;
        end
        default: if (busy_q && !adv_ni) step_q <= step_q + 1'b1;
      endcase
    end
  end

  assign step_o = step_q;
  assign last_o = busy_q & (&step_q);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_i,
  input  logic [BEAT_W-1:0] step_i,
  input  logic              inter_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] lin, ilv;

  assign lin    = base_i + step_i;  // wraps modulo 2**BEAT_W
  assign ilv    = base_i ^ step_i;
  assign beat_o = inter_i ? ilv : lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_pri_ni,
  input  logic              ce_hi_i,
  input  logic              ce_lo_ni,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  strb_ev_e          ev;
  logic [BEAT_W-1:0] step, beat;
  logic [ADDR_W-1:0] addr_q;

  burst_start_qual u_qual (
    .ce_pri_ni  (ce_pri_ni),
    .ce_hi_i    (ce_hi_i),
    .ce_lo_ni   (ce_lo_ni),
    .strb_cpu_ni(strb_cpu_ni),
    .strb_ctl_ni(strb_ctl_ni),
    .ev_o       (ev)
  );

  burst_step_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .adv_ni(adv_ni),
    .step_o(step),
    .last_o(last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              addr_q <= '0;
    else if (ev == EV_START)  addr_q <= addr_i;
  end

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_i (addr_q[BEAT_W-1:0]),
    .step_i (step),
    .inter_i(order_sel_i),
    .beat_o (beat)
  );

  assign addr_o = {addr_q[ADDR_W-1 -: HI_W], beat};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_pri_ni,
  input logic              ce_hi_i,
  input logic              ce_lo_ni,
  input logic              strb_cpu_ni,
  input logic              strb_ctl_ni,
  input logic              adv_ni,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o
);
  logic sel, no_ev;
  assign sel   = ~ce_pri_ni & ce_hi_i & ~ce_lo_ni;
  assign no_ev = ~((~strb_cpu_ni & ~ce_pri_ni) | ~strb_ctl_ni);

  // R2
  cpu_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && sel) |=> (addr_o == $past(addr_i) && !last_o));

  // R3
  ctl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_cpu_ni && !strb_ctl_ni && sel) |=> (addr_o == $past(addr_i)));

  // R5
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_ev && !sel) |=> !last_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_ev && adv_ni) |=> (!$stable(order_sel_i) || ($stable(addr_o) && $stable(last_o))));

  // R9
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_ev && !adv_ni && last_o) |=> !last_o);

  // R10
  upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_ev |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_pri_ni  (ce_pri_ni),
  .ce_hi_i    (ce_hi_i),
  .ce_lo_ni   (ce_lo_ni),
  .strb_cpu_ni(strb_cpu_ni),
  .strb_ctl_ni(strb_ctl_ni),
  .adv_ni     (adv_ni),
  .order_sel_i(order_sel_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .last_o     (last_o)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_pri_n = 1'b1, ce_hi = 1'b0, ce_lo_n = 1'b1;
  logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, order = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          last;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          last;
    string         tag;
  } exp_t;
  exp_t q[$];

  // bench model state
  logic          m_busy = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;

  always #2 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_pri_ni(ce_pri_n), .ce_hi_i(ce_hi),
    .ce_lo_ni(ce_lo_n), .strb_cpu_ni(cpu_n), .strb_ctl_ni(ctl_n),
    .adv_ni(adv_n), .order_sel_i(order), .addr_i(addr_in),
    .addr_o(addr_out), .last_o(last)
  );

  task automatic check(string tag, logic [AW-1:0] ea, logic el);
    n_chk++;
    if (addr_out !== ea || last !== el) begin
      n_bad++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
               tag, addr_out, last, ea, el);
    end
  endtask

  // one cycle: drive on the falling edge, predict state after the next rising edge
  task automatic cyc(input logic s_cpu, input logic s_ctl, input logic c_pri,
                     input logic c_hi, input logic c_lo, input logic a_n,
                     input logic [AW-1:0] a, input logic ord, input string tag);
    exp_t e;
    logic sel, ev;
    @(negedge clk);
    cpu_n = s_cpu; ctl_n = s_ctl; ce_pri_n = c_pri; ce_hi = c_hi;
    ce_lo_n = c_lo; adv_n = a_n; addr_in = a; order = ord;
    sel = !c_pri && c_hi && !c_lo;
    ev  = (!s_cpu && !c_pri) || !s_ctl;
    if (ev && sel) begin m_busy = 1'b1; m_base = a; m_step = 2'd0; end
    else if (ev)   begin m_busy = 1'b0; m_step = 2'd0; end
    else if (m_busy && !a_n) m_step = m_step + 2'd1;
    e.addr = {m_base[AW-1:2], ord ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step)};
    e.last = m_busy && (m_step == 2'd3);
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        check(e.tag, e.addr, e.last);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    #1;
    check("R1 reset", '0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1 after release", '0, 1'b0);
    // R5: advance while idle
    cyc(1,1,0,1,0,0,20'h55555,0,"R5 idle adv");
    cyc(1,1,0,1,0,0,20'h55555,0,"R5 idle adv");
    // R2: processor start, controller strobe and advance also low
    cyc(0,0,0,1,0,0,20'hABCD1,0,"R2 cpu start");
    // R7 linear 01,10,11,00 ; R10 upper bits kept
    cyc(1,1,0,1,0,0,20'h00000,0,"R7 step1");
    cyc(1,1,0,1,0,1,20'h00000,0,"R6 wait");
    cyc(1,1,0,1,0,0,20'h00000,0,"R7 step2");
    cyc(1,1,0,1,0,0,20'h00000,0,"R9 last beat");
    cyc(1,1,0,1,0,1,20'h00000,0,"R6 hold last");
    cyc(1,1,0,1,0,0,20'h00000,0,"R9 wrap");
    // R4: processor strobe ignored while primary select off
    cyc(0,1,1,1,0,0,20'h11112,0,"R4 cpu blocked");
    // R3: controller start, interleaved from 10
    cyc(1,0,0,1,0,0,20'h3C3C2,1,"R3 ctl start");
    cyc(1,1,0,1,0,0,20'h0,1,"R8 step1");
    cyc(1,1,0,1,0,0,20'h0,1,"R8 step2");
    cyc(1,1,0,1,0,0,20'h0,1,"R8 last R9");
    cyc(1,1,0,1,0,0,20'h0,1,"R9 wrap ilv");
    // R3: controller strobe low with processor low -> processor wins (same load)
    cyc(0,0,0,1,0,1,20'h7777F,1,"R2 cpu over ctl");
    // R5: controller strobe with chip not selected
    cyc(1,1,0,1,0,0,20'h0,0,"R7 step");
    cyc(1,0,0,0,0,0,20'h12345,0,"R5 deselect");
    cyc(1,1,0,1,0,0,20'h0,0,"R5 adv after desel");
    cyc(0,1,0,1,1,0,20'h0AAAA,0,"R5 cpu unselected");
    cyc(1,0,0,1,0,1,20'hFFFFF,0,"R3 ctl start top");
    cyc(1,1,0,1,0,0,20'h0,0,"R10 no carry");
    repeat (3) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule